// File: doc/BRIEF.md
# Multi-Channel Gain Bank Selector

This block sits between the configuration registers of an optical power monitor and its analog front end. It holds no configuration of its own. From the stored fields and one external pin it picks the single active set of front-end settings: a 12-bit fine-gain code, a 2-bit transimpedance gain code and a slow-tail compensation setting (enable, time constant, magnitude). It also reports which channel and which colour are active, and whether the front end should sleep with its outputs tri-stated.

Three colours are supported: blue, red and green. Each colour has a high bank and a low bank of fine gain. The high/low choice is the AND of a register bit and an external pin. The pin comes from another clock domain, so it is synchronized first. This allows two ways of switching. In fast hardware switching the register bit is parked at 1 and the pin toggles. In soft switching the pin is parked high and software toggles the bit. The colour comes from a blue-mode bit, which overrides a red/green bit.

Every output comes from one register stage. A change of bank therefore appears on all codes at the same clock edge.

Top module: `gain_bank_sel`

## Requirements
- R1: The high channel is active (`highActive`=1) exactly when both the synchronized `hlPin` and `hlBit` are 1. Otherwise the low channel is active. This supports switching by the pin (with `hlBit`=1) and switching by the bit (with `hlPin`=1).
- R2: A change on `hlPin` reaches the outputs on the third rising clock edge after it is sampled, through two synchronizer flops and the output register. A change on any register field reaches the outputs on the first rising edge.
- R3: When `blueMode`=1, blue is selected whatever the value of `redSel`. When `blueMode`=0, `redSel`=1 selects red and `redSel`=0 selects green. The `colourSel` output encodes green as 2'd0, red as 2'd1 and blue as 2'd2.
- R4: In every per-colour packed array, index 0 is blue, index 1 is red and index 2 is green. The high-bank fine code is {`upperHi`[c], `lowNibbles`[c][7:4]}. The low-bank fine code is {`upperLo`[c], `lowNibbles`[c][3:0]}. `fineGain` carries the code of the selected colour and bank.
- R5: `tiaGain` equals `tiaHi` while the high channel is active and `tiaLo` otherwise. Codes 0 to 3 run from the lowest to the highest gain.
- R6: `stEnOut`, `stTimeOut` and `stMagOut` follow the slow-tail setting of the selected colour.
- R7: When the slow-tail enable of the selected colour is 0, `stTimeOut` and `stMagOut` are 3'b000, whatever the stored fields hold.
- R8: When `chipEn`=0, both `sleepOut` and `hizReq` are 1. When `chipEn`=1, both are 0.
- R9: While reset is held, `fineGain`, `tiaGain` and all slow-tail outputs are 0, `highActive` is 0, `colourSel` is green, and `sleepOut` and `hizReq` are 1.
- R10: When the bank changes, `fineGain` and `tiaGain` both switch on the same clock edge. No cycle ever shows a code from one bank next to a code from the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hlPin | input | 1 | External high/low select pin (asynchronous) |
| hlBit | input | 1 | High/low register bit |
| blueMode | input | 1 | Blue override bit |
| redSel | input | 1 | Red (1) or green (0) choice |
| chipEn | input | 1 | Chip enable bit; 0 requests sleep |
| upperHi | input | 3x8 | High-bank fine code bits [11:4], per colour |
| upperLo | input | 3x8 | Low-bank fine code bits [11:4], per colour |
| lowNibbles | input | 3x8 | Shared low bits per colour: [7:4] high bank, [3:0] low bank |
| tiaHi | input | 2 | Transimpedance code for the high channel |
| tiaLo | input | 2 | Transimpedance code for the low channel |
| stEn | input | 3 | Slow-tail enable per colour |
| stTime | input | 3x3 | Slow-tail time constant per colour |
| stMag | input | 3x3 | Slow-tail magnitude per colour |
| fineGain | output | 12 | Active fine-gain code |
| tiaGain | output | 2 | Active transimpedance code |
| stEnOut | output | 1 | Active slow-tail enable |
| stTimeOut | output | 3 | Active slow-tail time constant |
| stMagOut | output | 3 | Active slow-tail magnitude |
| highActive | output | 1 | 1 when the high channel is active |
| colourSel | output | 2 | Active colour (0 green, 1 red, 2 blue) |
| sleepOut | output | 1 | Sleep indication |
| hizReq | output | 1 | Output high-impedance request |

## Verification
A bank switch and a colour or code update can land on the same edge. The fine code and the transimpedance code must also turn over together in that cycle. The bench provokes this by giving the two banks fine codes and transimpedance codes that differ in every field. It then flips `hlBit`, and in another case flips the synchronized pin. It samples the outputs just before and just after the edge where the change is due. Both samples must show a complete high-bank set or a complete low-bank set, never a mix. The same edge-by-edge sampling shows that the pin path is two cycles slower than the register path.

// File: rtl/gbs_pkg.sv
package gbs_pkg;

  typedef enum logic [1:0] {
    COL_GREEN = 2'd0,
    COL_RED   = 2'd1,
    COL_BLUE  = 2'd2
  } colour_e;

  localparam int IDX_BLUE  = 0;
  localparam int IDX_RED   = 1;
  localparam int IDX_GREEN = 2;

  typedef struct packed {
    logic    selHigh;
    colour_e colour;
    logic    enable;
  } gbs_strobe_t;

endpackage

// File: rtl/gbs_sync.sv
module gbs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= 1'b0;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/gbs_ctrl.sv
module gbs_ctrl
  import gbs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hlPin,
  input  logic        hlBit,
  input  logic        blueMode,
  input  logic        redSel,
  input  logic        chipEn,
  output gbs_strobe_t strobe
);
  logic pinSynced;

  gbs_sync #(.STAGES(SYNC_STAGES)) u_pinSync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(hlPin),
    .syncOut(pinSynced)
  );

  always_comb begin
    strobe.selHigh = pinSynced & hlBit;
    strobe.enable  = chipEn;
    if (blueMode)    strobe.colour = COL_BLUE;
    else if (redSel) strobe.colour = COL_RED;
    else             strobe.colour = COL_GREEN;
  end
endmodule

// File: rtl/gbs_datapath.sv
module gbs_datapath
  import gbs_pkg::*;
#(
  parameter int COLOURS = 3,
  parameter int UPPER_W = 8,
  parameter int NIB_W   = 4,
  parameter int TIA_W   = 2,
  parameter int ST_W    = 3,
  localparam int FINE_W = UPPER_W + NIB_W
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  gbs_strobe_t                      strobe,
  input  logic [COLOURS-1:0][UPPER_W-1:0]  upperHi,
  input  logic [COLOURS-1:0][UPPER_W-1:0]  upperLo,
  input  logic [COLOURS-1:0][2*NIB_W-1:0]  lowNibbles,
  input  logic [TIA_W-1:0]                 tiaHi,
  input  logic [TIA_W-1:0]                 tiaLo,
  input  logic [COLOURS-1:0]               stEn,
  input  logic [COLOURS-1:0][ST_W-1:0]     stTime,
  input  logic [COLOURS-1:0][ST_W-1:0]     stMag,
  output logic [FINE_W-1:0]                fineGain,
  output logic [TIA_W-1:0]                 tiaGain,
  output logic                             stEnOut,
  output logic [ST_W-1:0]                  stTimeOut,
  output logic [ST_W-1:0]                  stMagOut,
  output logic                             highActive,
  output logic [1:0]                       colourSel,
  output logic                             sleepOut,
  output logic                             hizReq
);
  localparam int IDX_W = (COLOURS > 1) ? $clog2(COLOURS) : 1;

  logic [COLOURS-1:0][FINE_W-1:0] fineHiC, fineLoC;
  logic [COLOURS-1:0][ST_W-1:0]   timeC, magC;

  generate
    for (genvar c = 0; c < COLOURS; c++) begin : g_colour
      assign fineHiC[c] = {upperHi[c], lowNibbles[c][2*NIB_W-1:NIB_W]};
      assign fineLoC[c] = {upperLo[c], lowNibbles[c][NIB_W-1:0]};
      assign timeC[c]   = stEn[c] ? stTime[c] : '0;
      assign magC[c]    = stEn[c] ? stMag[c]  : '0;
    end
  endgenerate

  logic [IDX_W-1:0]  idx;
  logic [FINE_W-1:0] fineNext;
  logic [TIA_W-1:0]  tiaNext;

  always_comb begin
    case (strobe.colour)
      COL_BLUE: idx = IDX_W'(IDX_BLUE);
      COL_RED:  idx = IDX_W'(IDX_RED);
      default:  idx = IDX_W'(IDX_GREEN);
    endcase
    fineNext = strobe.selHigh ? fineHiC[idx] : fineLoC[idx];
    tiaNext  = strobe.selHigh ? tiaHi : tiaLo;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fineGain   <= '0;
      tiaGain    <= '0;
      stEnOut    <= 1'b0;
      stTimeOut  <= '0;
      stMagOut   <= '0;
      highActive <= 1'b0;
      colourSel  <= COL_GREEN;
      sleepOut   <= 1'b1;
      hizReq     <= 1'b1;
    end else begin
      fineGain   <= fineNext;
      tiaGain    <= tiaNext;
      stEnOut    <= stEn[idx];
      stTimeOut  <= timeC[idx];
      stMagOut   <= magC[idx];
      highActive <= strobe.selHigh;
      colourSel  <= strobe.colour;
      sleepOut   <= ~strobe.enable;
      hizReq     <= ~strobe.enable;
    end
  end
endmodule

// File: rtl/gain_bank_sel.sv
module gain_bank_sel
  import gbs_pkg::*;
#(
  parameter int COLOURS     = 3,
  parameter int UPPER_W     = 8,
  parameter int NIB_W       = 4,
  parameter int TIA_W       = 2,
  parameter int ST_W        = 3,
  parameter int SYNC_STAGES = 2,
  localparam int FINE_W     = UPPER_W + NIB_W
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             hlPin,
  input  logic                             hlBit,
  input  logic                             blueMode,
  input  logic                             redSel,
  input  logic                             chipEn,
  input  logic [COLOURS-1:0][UPPER_W-1:0]  upperHi,
  input  logic [COLOURS-1:0][UPPER_W-1:0]  upperLo,
  input  logic [COLOURS-1:0][2*NIB_W-1:0]  lowNibbles,
  input  logic [TIA_W-1:0]                 tiaHi,
  input  logic [TIA_W-1:0]                 tiaLo,
  input  logic [COLOURS-1:0]               stEn,
  input  logic [COLOURS-1:0][ST_W-1:0]     stTime,
  input  logic [COLOURS-1:0][ST_W-1:0]     stMag,
  output logic [FINE_W-1:0]                fineGain,
  output logic [TIA_W-1:0]                 tiaGain,
  output logic                             stEnOut,
  output logic [ST_W-1:0]                  stTimeOut,
  output logic [ST_W-1:0]                  stMagOut,
  output logic                             highActive,
  output logic [1:0]                       colourSel,
  output logic                             sleepOut,
  output logic                             hizReq
);
  gbs_strobe_t strobe;

  gbs_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .hlPin   (hlPin),
    .hlBit   (hlBit),
    .blueMode(blueMode),
    .redSel  (redSel),
    .chipEn  (chipEn),
    .strobe  (strobe)
  );

  gbs_datapath #(
    .COLOURS(COLOURS), .UPPER_W(UPPER_W), .NIB_W(NIB_W),
    .TIA_W(TIA_W), .ST_W(ST_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .upperHi   (upperHi),
    .upperLo   (upperLo),
    .lowNibbles(lowNibbles),
    .tiaHi     (tiaHi),
    .tiaLo     (tiaLo),
    .stEn      (stEn),
    .stTime    (stTime),
    .stMag     (stMag),
    .fineGain  (fineGain),
    .tiaGain   (tiaGain),
    .stEnOut   (stEnOut),
    .stTimeOut (stTimeOut),
    .stMagOut  (stMagOut),
    .highActive(highActive),
    .colourSel (colourSel),
    .sleepOut  (sleepOut),
    .hizReq    (hizReq)
  );
endmodule

// File: rtl/gbs_checker.sv
module gbs_checker #(
  parameter int TIA_W = 2,
  parameter int ST_W  = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             hlPin,
  input logic             hlBit,
  input logic             blueMode,
  input logic             chipEn,
  input logic [TIA_W-1:0] tiaHi,
  input logic [TIA_W-1:0] tiaLo,
  input logic [TIA_W-1:0] tiaGain,
  input logic             stEnOut,
  input logic [ST_W-1:0]  stTimeOut,
  input logic [ST_W-1:0]  stMagOut,
  input logic             highActive,
  input logic [1:0]       colourSel,
  input logic             sleepOut,
  input logic             hizReq
);
  logic [1:0] armCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              armCnt <= '0;
    else if (armCnt != 2'd3) armCnt <= armCnt + 2'd1;
  end

  // R1: the high channel needs the register bit one edge earlier
  assert_high_needs_bit_R1: assert property (@(posedge clk) disable iff (!rstN)
    (armCnt >= 2'd1 && highActive) |-> $past(hlBit));

  // R2: the high channel needs the pin three edges earlier (synchronizer latency)
  assert_high_needs_pin_R2: assert property (@(posedge clk) disable iff (!rstN)
    (armCnt == 2'd3 && highActive) |-> $past(hlPin, 3));

  // R3: blue mode wins
  assert_blue_override_R3: assert property (@(posedge clk) disable iff (!rstN)
    (armCnt >= 2'd1 && $past(blueMode)) |-> colourSel == 2'd2);

  // R5: equal codes in both banks give that code
  assert_tia_common_R5: assert property (@(posedge clk) disable iff (!rstN)
    (armCnt >= 2'd1 && $past(tiaHi == tiaLo)) |-> tiaGain == $past(tiaHi));

  // R7: a disabled slow tail shows zero fields
  assert_st_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    !stEnOut |-> (stTimeOut == '0 && stMagOut == '0));

  // R8: sleep and high-impedance request agree and follow the enable bit
  assert_sleep_hiz_R8: assert property (@(posedge clk) disable iff (!rstN)
    sleepOut == hizReq);
  assert_awake_R8: assert property (@(posedge clk) disable iff (!rstN)
    (armCnt >= 2'd1 && $past(chipEn)) |-> !sleepOut);
endmodule

bind gain_bank_sel gbs_checker #(.TIA_W(TIA_W), .ST_W(ST_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .hlPin     (hlPin),
  .hlBit     (hlBit),
  .blueMode  (blueMode),
  .chipEn    (chipEn),
  .tiaHi     (tiaHi),
  .tiaLo     (tiaLo),
  .tiaGain   (tiaGain),
  .stEnOut   (stEnOut),
  .stTimeOut (stTimeOut),
  .stMagOut  (stMagOut),
  .highActive(highActive),
  .colourSel (colourSel),
  .sleepOut  (sleepOut),
  .hizReq    (hizReq)
);

// File: tb/sim_gain_bank_sel.sv
module sim_gain_bank_sel;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic hlPin = 0, hlBit = 0, blueMode = 0, redSel = 0, chipEn = 0;
  logic [2:0][7:0] upperHi, upperLo, lowNibbles;
  logic [1:0] tiaHi, tiaLo;
  logic [2:0] stEn;
  logic [2:0][2:0] stTime, stMag;
  logic [11:0] fineGain;
  logic [1:0] tiaGain, colourSel;
  logic stEnOut, highActive, sleepOut, hizReq;
  logic [2:0] stTimeOut, stMagOut;

  gain_bank_sel u0 (
    .clk(clk), .rstN(rstN), .hlPin(hlPin), .hlBit(hlBit), .blueMode(blueMode),
    .redSel(redSel), .chipEn(chipEn), .upperHi(upperHi), .upperLo(upperLo),
    .lowNibbles(lowNibbles), .tiaHi(tiaHi), .tiaLo(tiaLo), .stEn(stEn),
    .stTime(stTime), .stMag(stMag), .fineGain(fineGain), .tiaGain(tiaGain),
    .stEnOut(stEnOut), .stTimeOut(stTimeOut), .stMagOut(stMagOut),
    .highActive(highActive), .colourSel(colourSel), .sleepOut(sleepOut),
    .hizReq(hizReq)
  );

  typedef struct {
    logic [11:0] fine;
    logic [1:0]  tia;
    logic        en;
    logic [2:0]  tm;
    logic [2:0]  mg;
    logic        high;
    logic [1:0]  col;
    logic        sleep;
    string       req;
  } exp_t;

  exp_t expQ[$];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  function automatic exp_t model(string req);
    exp_t e;
    int c;
    logic h;
    h = hlPin & hlBit;
    if (blueMode)    begin c = 0; e.col = 2'd2; end
    else if (redSel) begin c = 1; e.col = 2'd1; end
    else             begin c = 2; e.col = 2'd0; end
    e.fine  = h ? {upperHi[c], lowNibbles[c][7:4]} : {upperLo[c], lowNibbles[c][3:0]};
    e.tia   = h ? tiaHi : tiaLo;
    e.en    = stEn[c];
    e.tm    = stEn[c] ? stTime[c] : 3'd0;
    e.mg    = stEn[c] ? stMag[c] : 3'd0;
    e.high  = h;
    e.sleep = ~chipEn;
    e.req   = req;
    return e;
  endfunction

  task automatic compare(exp_t e);
    bit bad;
    checks++;
    bad = (fineGain !== e.fine) || (tiaGain !== e.tia) || (stEnOut !== e.en) ||
          (stTimeOut !== e.tm) || (stMagOut !== e.mg) || (highActive !== e.high) ||
          (colourSel !== e.col) || (sleepOut !== e.sleep) || (hizReq !== e.sleep);
    if (bad) begin
      fails++;
      $display("FAIL %s: got fine=%h tia=%0d st=%b/%0d/%0d hi=%b col=%0d slp=%b hiz=%b, exp fine=%h tia=%0d st=%b/%0d/%0d hi=%b col=%0d slp=%b",
               e.req, fineGain, tiaGain, stEnOut, stTimeOut, stMagOut, highActive,
               colourSel, sleepOut, hizReq, e.fine, e.tia, e.en, e.tm, e.mg,
               e.high, e.col, e.sleep);
    end
  endtask

  task automatic checkVal(string req, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: inputs already set at a negedge; let them settle, then queue the expectation
  task automatic settleAndExpect(string req);
    repeat (3) @(posedge clk);
    #2;
    expQ.push_back(model(req));
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      while (expQ.size() > 0) compare(expQ.pop_front());
    end
  end

  // watchdog
  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    upperHi    = {8'hA1, 8'h52, 8'h3C};   // green, red, blue
    upperLo    = {8'hE8, 8'h6B, 8'h15};
    lowNibbles = {8'hD2, 8'h47, 8'h9E};
    tiaHi = 2'b11; tiaLo = 2'b01;
    stEn   = 3'b011;                       // green disabled
    stTime = {3'd7, 3'd2, 3'd5};
    stMag  = {3'd7, 3'd6, 3'd3};

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    checks++;
    if (fineGain !== 12'h0 || tiaGain !== 2'd0 || stEnOut !== 1'b0 || stTimeOut !== 3'd0 ||
        stMagOut !== 3'd0 || highActive !== 1'b0 || colourSel !== 2'd0 ||
        sleepOut !== 1'b1 || hizReq !== 1'b1) begin
      fails++;
      $display("FAIL R9: actual fine=%h tia=%0d hi=%b col=%0d slp=%b hiz=%b expected 0/0/0/0/1/1",
               fineGain, tiaGain, highActive, colourSel, sleepOut, hizReq);
    end
    rstN = 1'b1;

    @(negedge clk); chipEn = 1; hlPin = 1; hlBit = 1; blueMode = 1;
    settleAndExpect("R3 R4 R5 R6 blue high");
    @(negedge clk); hlBit = 0;
    settleAndExpect("R1 R4 R5 blue low soft");
    @(negedge clk); blueMode = 0; redSel = 1; hlBit = 1;
    settleAndExpect("R3 R4 R6 red high");
    @(negedge clk); hlPin = 0;
    settleAndExpect("R1 R4 red low hard");
    @(negedge clk); redSel = 0; hlPin = 1;
    settleAndExpect("R3 R4 R7 green high st disabled");
    @(negedge clk); hlBit = 0;
    settleAndExpect("R4 R7 green low");
    @(negedge clk); blueMode = 1; redSel = 1; hlBit = 1;
    settleAndExpect("R3 blue overrides red");
    @(negedge clk); chipEn = 0;
    settleAndExpect("R8 sleep");
    @(negedge clk); chipEn = 1; hlPin = 0; hlBit = 0;
    settleAndExpect("R1 R8 both low awake");

    // R2: pin path needs three edges, register path one
    @(negedge clk); blueMode = 0; redSel = 1; hlBit = 1; hlPin = 0;
    repeat (3) @(negedge clk);
    hlPin = 1;
    @(negedge clk); checkVal("R2 pin after 1 edge", {11'd0, highActive}, 12'd0);
    @(negedge clk); checkVal("R2 pin after 2 edges", {11'd0, highActive}, 12'd0);
    @(negedge clk); checkVal("R2 pin after 3 edges", {11'd0, highActive}, 12'd1);
    checkVal("R2 R4 fine after pin", fineGain, 12'h524);
    hlBit = 0;
    @(negedge clk); checkVal("R2 bit after 1 edge", fineGain, 12'h6B7);

    // R10: bank flip by register bit, fine and tia change together
    hlBit = 1;
    checkVal("R10 before edge", {fineGain, tiaGain} >> 2, {12'h6B7, 2'b01} >> 2);
    checkVal("R10 tia before edge", {10'd0, tiaGain}, 12'd1);
    @(negedge clk);
    checkVal("R10 fine after edge", fineGain, 12'h524);
    checkVal("R10 tia after edge", {10'd0, tiaGain}, 12'd3);

    // R10: bank flip by pin, both codes change on the same edge
    hlPin = 0;
    @(negedge clk); @(negedge clk);
    checkVal("R10 pin hold fine", fineGain, 12'h524);
    checkVal("R10 pin hold tia", {10'd0, tiaGain}, 12'd3);
    @(negedge clk);
    checkVal("R10 pin flip fine", fineGain, 12'h6B7);
    checkVal("R10 pin flip tia", {10'd0, tiaGain}, 12'd1);

    repeat (4) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule